// File: doc/BRIEF.md
# Genotype Mutation and Selection Engine

This engine builds one new generation of configuration bit strings for an evolution experiment run on a cell array. Each genotype is a set of cells. Each cell holds several multiplexer fields, and the whole set is kept in an external synchronous genotype memory with one word per cell. A host first writes a fitness score for every individual. It then pulses `start` with a mode and the number of the bank that holds the current parents. The engine ranks the population, copies the fittest genotype unchanged into child slot 0 of the other bank, and fills the remaining slots with mutated copies of parents drawn by linear rank.

Three modes are available:
- **Bit-flip:** every bit is inverted with a small fixed probability.
- **Cell-reconfiguration:** a fixed number of randomly placed multiplexer fields are rewritten.
- **Random fill:** seeds the first generation.

Every random choice comes from one 32-bit LFSR, so a run repeats when the same seed is loaded.

Top module: `evo_gen_engine`

## Requirements
- R1: After reset `busy`, `done` and `mem_we` are all low.
- R2: Individuals are ranked by fitness, highest first. Equal scores keep the lower index ahead.
- R3: In bit-flip (`mode`=0) and cell-reconfiguration (`mode`=1) modes, child slot 0 is an exact copy of the top-ranked parent.
- R4: Each other child's parent is drawn with weight POP-1-r for rank r. The top rank is therefore drawn twice as often as the median rank, and the last rank is never drawn.
- R5: In bit-flip mode each bit of a non-elite child is inverted when a fresh 16-bit random sample is below floor(MUT_RATE_X100*65536/(100*genome bits)). This gives about 2.7 flips per genotype.
- R6: In cell-reconfiguration mode a non-elite child differs from its parent in at most CELL_MUTS multiplexer fields. Field m of a cell word occupies bits [m*FIELD_W +: FIELD_W].
- R7: In random-fill mode (`mode`=2) every word of every slot of the destination bank receives random content.
- R8: Memory addresses are {bank, individual, cell}, from most to least significant. Reads use bank `src_bank` and writes use the other bank. Each destination word is written exactly once per generation.
- R9: `busy` stays high from an accepted start to the end of the run. `done` is a single-cycle pulse in the cycle after the cycle that carries the last write.
- R10: A seed written with `seed_we` makes the following run repeat exactly. A seed of zero behaves as a seed of one.
- R11: A `start` pulse while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one generation (accepted when idle) |
| mode | input | 2 | 0 bit-flip, 1 cell-reconfiguration, 2 random fill |
| src_bank | input | 1 | Bank holding the parents; children go to the other bank |
| seed_we | input | 1 | Load `seed` into the LFSR |
| seed | input | 32 | LFSR seed |
| fit_we | input | 1 | Fitness score write strobe |
| fit_idx | input | $clog2(POP) | Individual whose score is written |
| fit_val | input | FIT_W | Fitness score |
| mem_addr | output | 1+$clog2(POP)+$clog2(CELLS) | Genotype memory address |
| mem_we | output | 1 | Genotype memory write enable |
| mem_wdata | output | MUXES*FIELD_W | Child cell word |
| mem_rdata | input | MUXES*FIELD_W | Parent cell word, one cycle after address |
| busy | output | 1 | Generation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two things can fall in the same cycle: a second `start` pulse and an active run, which may be selecting a parent or writing memory at that moment. The bench provokes this by pulsing `start` while the engine is mid-generation. It then judges the result from the write counts per address and the number of `done` pulses. A second overlap is the final write and the `done` pulse. The bench checks these by recording the cycle of the last write enable and the cycle in which `done` appears. They must be exactly one cycle apart, and each destination word must have been written exactly once.

// File: rtl/evo_pkg.sv
package evo_pkg;

  typedef enum logic [1:0] {
    MODE_BITFLIP = 2'd0,
    MODE_CELLMUT = 2'd1,
    MODE_RANDOM  = 2'd2
  } evo_mode_e;

  localparam logic [31:0] LFSR_MASK = 32'h8020_0003;

  function automatic logic [31:0] lfsr_advance(input logic [31:0] s, input int steps);
    logic [31:0] v;
    v = s;
    for (int k = 0; k < steps; k++) begin
      v = {1'b0, v[31:1]} ^ (v[0] ? LFSR_MASK : 32'h0);
    end
    return v;
  endfunction

endpackage

// File: rtl/evo_lfsr.sv
module evo_lfsr #(
  parameter int STEPS = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        seed_we,
  input  logic [31:0] seed,
  output logic [31:0] state
);
  import evo_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= 32'h1;
    end else if (seed_we) begin
      state <= (seed == 32'h0) ? 32'h1 : seed;
    end else begin
      state <= lfsr_advance(state, STEPS);
    end
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    state != 32'h0); // R10

endmodule

// File: rtl/evo_ranker.sv
module evo_ranker #(
  parameter int POP   = 50,
  parameter int FIT_W = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          fit_we,
  input  logic [$clog2(POP)-1:0]        fit_idx,
  input  logic [FIT_W-1:0]              fit_val,
  input  logic                          start,
  output logic                          done,
  output logic [POP-1:0][$clog2(POP)-1:0] order
);
  localparam int IW = $clog2(POP);
  localparam logic [IW-1:0] LAST = IW'(POP - 1);

  typedef enum logic [1:0] {R_IDLE, R_LOAD, R_SHIFT} rstate_e;
  rstate_e             st;
  logic [FIT_W-1:0]    fit_q [POP];
  logic [IW-1:0]       i_q, j_q;
  logic [FIT_W-1:0]    key_q;
  logic [IW-1:0]       jm1;

  assign jm1 = j_q - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= R_IDLE;
      done  <= 1'b0;
      order <= '0;
      i_q   <= '0;
      j_q   <= '0;
      key_q <= '0;
      for (int k = 0; k < POP; k++) fit_q[k] <= '0;
    end else begin
      done <= 1'b0;
      if (fit_we && fit_idx <= LAST) fit_q[fit_idx] <= fit_val;
      case (st)
        R_IDLE: if (start) begin
          order[0] <= '0;
          i_q      <= IW'(1);
          st       <= R_LOAD;
        end
        R_LOAD: begin
          key_q <= fit_q[i_q];
          j_q   <= i_q;
          st    <= R_SHIFT;
        end
        default: begin
          if (j_q != '0 && fit_q[order[jm1]] < key_q) begin
            order[j_q] <= order[jm1];
            j_q        <= jm1;
          end else begin
            order[j_q] <= i_q;
            if (i_q == LAST) begin
              done <= 1'b1;
              st   <= R_IDLE;
            end else begin
              i_q <= i_q + 1'b1;
              st  <= R_LOAD;
            end
          end
        end
      endcase
    end
  end

  for (genvar r = 0; r < POP - 1; r++) begin : g_ord
    AST_RANK_ORDER: assert property (@(posedge clk) disable iff (rst)
      done |-> (fit_q[order[r]] > fit_q[order[r+1]]) ||
               (fit_q[order[r]] == fit_q[order[r+1]] && order[r] < order[r+1])); // R2
  end

endmodule

// File: rtl/evo_gen_engine.sv
module evo_gen_engine #(
  parameter int POP           = 50,
  parameter int CELLS         = 100,
  parameter int MUXES         = 3,
  parameter int FIELD_W       = 6,
  parameter int CELL_MUTS     = 3,
  parameter int FIT_W         = 16,
  parameter int MUT_RATE_X100 = 270
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       start,
  input  logic [1:0]                                 mode,
  input  logic                                       src_bank,
  input  logic                                       seed_we,
  input  logic [31:0]                                seed,
  input  logic                                       fit_we,
  input  logic [$clog2(POP)-1:0]                     fit_idx,
  input  logic [FIT_W-1:0]                           fit_val,
  output logic [$clog2(POP)+$clog2(CELLS):0]         mem_addr,
  output logic                                       mem_we,
  output logic [MUXES*FIELD_W-1:0]                   mem_wdata,
  input  logic [MUXES*FIELD_W-1:0]                   mem_rdata,
  output logic                                       busy,
  output logic                                       done
);
  import evo_pkg::*;

  localparam int CELL_BITS   = MUXES * FIELD_W;
  localparam int GENOME_BITS = CELLS * CELL_BITS;
  localparam int IW          = $clog2(POP);
  localparam int CW          = $clog2(CELLS);
  localparam int MW          = (MUXES > 1) ? $clog2(MUXES) : 1;
  localparam int AW          = 1 + IW + CW;
  localparam int TOTAL_W     = POP * (POP - 1) / 2;
  localparam int WW          = $clog2(TOTAL_W + 1);
  localparam int PW          = $clog2(CELL_MUTS + 1);
  localparam int BW          = $clog2(CELL_BITS + 1);
  localparam int THRESH      = (MUT_RATE_X100 * 65536) / (100 * GENOME_BITS);
  localparam logic [IW-1:0]  LAST_IND  = IW'(POP - 1);
  localparam logic [CW-1:0]  LAST_CELL = CW'(CELLS - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RANK, S_CHILD, S_SEL, S_PICK, S_MASK, S_RD, S_WT, S_WR, S_FLUSH
  } state_e;

  state_e                       st;
  evo_mode_e                    mode_q;
  logic                         bank_q;
  logic [IW-1:0]                child_q, parent_q, r_q;
  logic [CW-1:0]                cell_q;
  logic [WW-1:0]                acc_q, u_q;
  logic                         mut_en_q;
  logic [PW-1:0]                pick_n_q;
  logic [BW-1:0]                bit_q;
  logic [CELL_BITS-1:0]         mask_q;
  logic [CW-1:0]                pick_cell_q [CELL_MUTS];
  logic [MW-1:0]                pick_mux_q  [CELL_MUTS];
  logic [FIELD_W-1:0]           pick_val_q  [CELL_MUTS];

  logic [31:0]                  rnd;
  logic                         rank_start, rank_done;
  logic [POP-1:0][IW-1:0]       order;

  // random draws scaled by multiplication rather than modulo
  logic [47:0]                  prod_u;
  logic [31:0]                  prod_c;
  logic [15:0]                  prod_m;
  logic [WW-1:0]                draw_u;
  logic [CW-1:0]                draw_cell;
  logic [MW-1:0]                draw_mux;
  logic [CELL_BITS-1:0]         new_word;

  assign rank_start = (st == S_IDLE) && start;

  evo_lfsr #(.STEPS(16)) u_lfsr (
    .clk(clk), .rst(rst), .seed_we(seed_we), .seed(seed), .state(rnd)
  );

  evo_ranker #(.POP(POP), .FIT_W(FIT_W)) u_rank (
    .clk(clk), .rst(rst), .fit_we(fit_we), .fit_idx(fit_idx), .fit_val(fit_val),
    .start(rank_start), .done(rank_done), .order(order)
  );

  always_comb begin
    prod_u    = {32'h0, rnd[31:16]} * 48'(TOTAL_W);
    prod_c    = {16'h0, rnd[15:0]} * 32'(CELLS);
    prod_m    = {8'h0, rnd[23:16]} * 16'(MUXES);
    draw_u    = prod_u[16 +: WW];
    draw_cell = prod_c[16 +: CW];
    draw_mux  = prod_m[8 +: MW];
  end

  always_comb begin
    new_word = mem_rdata;
    if (mode_q == MODE_RANDOM) begin
      new_word = rnd[CELL_BITS-1:0];
    end else if (mut_en_q && mode_q == MODE_BITFLIP) begin
      new_word = mem_rdata ^ mask_q;
    end else if (mut_en_q && mode_q == MODE_CELLMUT) begin
      for (int j = 0; j < CELL_MUTS; j++) begin
        if (pick_cell_q[j] == cell_q)
          new_word[pick_mux_q[j]*FIELD_W +: FIELD_W] = pick_val_q[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      mode_q    <= MODE_BITFLIP;
      bank_q    <= 1'b0;
      child_q   <= '0;
      parent_q  <= '0;
      r_q       <= '0;
      cell_q    <= '0;
      acc_q     <= '0;
      u_q       <= '0;
      mut_en_q  <= 1'b0;
      pick_n_q  <= '0;
      bit_q     <= '0;
      mask_q    <= '0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      for (int j = 0; j < CELL_MUTS; j++) begin
        pick_cell_q[j] <= '0;
        pick_mux_q[j]  <= '0;
        pick_val_q[j]  <= '0;
      end
    end else begin
      mem_we <= 1'b0;
      done   <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          mode_q  <= evo_mode_e'(mode);
          bank_q  <= src_bank;
          child_q <= '0;
          busy    <= 1'b1;
          st      <= S_RANK;
        end
        S_RANK: if (rank_done) st <= S_CHILD;
        S_CHILD: begin
          mut_en_q <= (child_q != '0);
          pick_n_q <= '0;
          bit_q    <= '0;
          mask_q   <= '0;
          cell_q   <= '0;
          if (mode_q == MODE_RANDOM) begin
            st <= S_RD;
          end else if (child_q == '0) begin
            parent_q <= order[0];
            st       <= S_RD;
          end else begin
            u_q   <= draw_u;
            r_q   <= '0;
            acc_q <= WW'(POP - 1);
            st    <= S_SEL;
          end
        end
        S_SEL: begin
          if (u_q < acc_q) begin
            parent_q <= order[r_q];
            st       <= (mode_q == MODE_CELLMUT) ? S_PICK : S_MASK;
          end else begin
            r_q   <= r_q + 1'b1;
            acc_q <= acc_q + WW'(POP - 2) - WW'(r_q);
          end
        end
        S_PICK: begin
          pick_cell_q[pick_n_q] <= draw_cell;
          pick_mux_q[pick_n_q]  <= draw_mux;
          pick_val_q[pick_n_q]  <= rnd[24 +: FIELD_W];
          if (pick_n_q == PW'(CELL_MUTS - 1)) st <= S_RD;
          else pick_n_q <= pick_n_q + 1'b1;
        end
        S_MASK: begin
          mask_q[bit_q] <= (rnd[15:0] < 16'(THRESH));
          if (bit_q == BW'(CELL_BITS - 1)) begin
            bit_q <= '0;
            st    <= S_RD;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        S_RD: begin
          mem_addr <= {bank_q, parent_q, cell_q};
          st       <= S_WT;
        end
        S_WT: st <= S_WR;
        S_WR: begin
          mem_addr  <= {~bank_q, child_q, cell_q};
          mem_we    <= 1'b1;
          mem_wdata <= new_word;
          if (cell_q == LAST_CELL) begin
            st <= S_FLUSH;
          end else begin
            cell_q <= cell_q + 1'b1;
            st     <= (mut_en_q && mode_q == MODE_BITFLIP) ? S_MASK : S_RD;
          end
        end
        S_FLUSH: begin
          if (child_q == LAST_IND) begin
            done <= 1'b1;
            busy <= 1'b0;
            st   <= S_IDLE;
          end else begin
            child_q <= child_q + 1'b1;
            st      <= S_CHILD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_WRITE_DEST: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[AW-1] != bank_q)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_WORST_NEVER: assert property (@(posedge clk) disable iff (rst)
    (st == S_SEL && u_q < acc_q) |-> (r_q != LAST_IND)); // R4

  AST_ELITE_COPY: assert property (@(posedge clk) disable iff (rst)
    (mem_we && child_q == '0 && mode_q != MODE_RANDOM) |-> (mem_wdata == $past(mem_rdata))); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_we); // R11

endmodule

// File: tb/tb_evo_gen_engine.sv
module tb_evo_gen_engine;
  localparam int CLK_PERIOD = 10;
  localparam int POP   = 4;
  localparam int CELLS = 4;
  localparam int MUXES = 3;
  localparam int FW    = 2;
  localparam int CMUT  = 3;
  localparam int FIT_W = 8;
  localparam int IW    = $clog2(POP);
  localparam int CW    = $clog2(CELLS);
  localparam int AW    = 1 + IW + CW;
  localparam int CB    = MUXES * FW;
  localparam int GBITS = CELLS * CB;
  localparam int THR   = (270 * 65536) / (100 * GBITS);

  logic clk = 0, rst = 1, start = 0, src_bank = 0, seed_we = 0, fit_we = 0;
  logic [1:0] mode = 0;
  logic [31:0] seed = 0;
  logic [IW-1:0] fit_idx = 0;
  logic [FIT_W-1:0] fit_val = 0;
  logic [AW-1:0] mem_addr;
  logic mem_we;
  logic [CB-1:0] mem_wdata, mem_rdata;
  logic busy, done;

  logic [CB-1:0] ram [2**AW];
  int wcnt [2**AW];
  int checks = 0, fails = 0, cyc = 0, last_we = -1, done_at = -1, done_cnt = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evo_gen_engine #(.POP(POP), .CELLS(CELLS), .MUXES(MUXES), .FIELD_W(FW),
    .CELL_MUTS(CMUT), .FIT_W(FIT_W), .MUT_RATE_X100(270)) dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .src_bank(src_bank),
    .seed_we(seed_we), .seed(seed), .fit_we(fit_we), .fit_idx(fit_idx),
    .fit_val(fit_val), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done));

  // synchronous genotype memory model, read latency one cycle
  always @(posedge clk) begin
    if (mem_we) begin
      ram[mem_addr]  <= mem_wdata;
      wcnt[mem_addr] <= wcnt[mem_addr] + 1;
    end
    mem_rdata <= ram[mem_addr];
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mem_we) last_we = cyc;
    if (done) begin done_at = cyc; done_cnt = done_cnt + 1; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int adr(input int b, input int i, input int c);
    return (b << (IW + CW)) | (i << CW) | c;
  endfunction

  function automatic int field(input int b, input int i, input int c, input int m);
    logic [CB-1:0] w;
    w = ram[adr(b, i, c)];
    return int'((w >> (m * FW)) & CB'((1 << FW) - 1));
  endfunction

  // parents: every field of individual p holds value p, so all pairs differ in every field
  task automatic init_parents();
    for (int p = 0; p < POP; p++)
      for (int c = 0; c < CELLS; c++) begin
        logic [CB-1:0] w;
        w = '0;
        for (int m = 0; m < MUXES; m++) w = w | (CB'(p) << (m * FW));
        ram[adr(0, p, c)] = w;
      end
  endtask

  task automatic nearest(input int b, input int i, output int pb, output int fd, output int hb);
    fd = 1000;
    pb = 0;
    for (int p = 0; p < POP; p++) begin
      int d;
      d = 0;
      for (int c = 0; c < CELLS; c++)
        for (int m = 0; m < MUXES; m++)
          if (field(b, i, c, m) != p) d++;
      if (d < fd) begin fd = d; pb = p; end
    end
    hb = 0;
    for (int c = 0; c < CELLS; c++)
      for (int m = 0; m < MUXES; m++)
        hb += $countones(FW'(field(b, i, c, m) ^ pb));
  endtask

  task automatic load_fit(input int f0, input int f1, input int f2, input int f3);
    int f [4];
    f = '{f0, f1, f2, f3};
    for (int k = 0; k < POP; k++) begin
      @(negedge clk);
      fit_we = 1; fit_idx = IW'(k); fit_val = FIT_W'(f[k]);
    end
    @(negedge clk);
    fit_we = 0;
  endtask

  task automatic load_seed(input logic [31:0] s);
    @(negedge clk);
    seed_we = 1; seed = s;
    @(negedge clk);
    seed_we = 0;
  endtask

  task automatic run_gen(input int md, input bit sb, input bit extra);
    int d0, waited;
    for (int a = 0; a < 2**AW; a++) wcnt[a] = 0;
    @(negedge clk);
    mode = 2'(md); src_bank = sb; start = 1;
    @(negedge clk);
    start = 0;
    d0 = done_cnt;
    if (extra) begin
      repeat (20) @(negedge clk);
      chk(busy == 1'b1, "R9 busy mid-run", int'(busy), 1);
      start = 1; mode = 2'd2;
      @(negedge clk);
      start = 0;
    end
    waited = 0;
    while (done_cnt == d0 && waited < 5000) begin @(negedge clk); waited++; end
    chk(done_cnt == d0 + 1, "R9 done seen", done_cnt - d0, 1);
    chk(done_at == last_we + 1, "R9 done timing", done_at - last_we, 1);
    repeat (40) @(negedge clk);
    chk(busy == 1'b0 && done_cnt == d0 + 1, "R11 single run", done_cnt - d0, 1);
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < POP; i++)
        for (int c = 0; c < CELLS; c++) begin
          if (wcnt[adr(!sb, i, c)] != 1) bad++;
          if (wcnt[adr(sb, i, c)] != 0) bad++;
        end
      chk(bad == 0, "R8 write map", bad, 0);
    end
  endtask

  task automatic check_gen(input int elite, input int worst, input bit is_cell,
                           inout int tally [4], inout int flips);
    int pb, fd, hb;
    nearest(1, 0, pb, fd, hb);
    chk(pb == elite && fd == 0, "R3 elite copy", pb * 100 + fd, elite * 100);
    for (int i = 1; i < POP; i++) begin
      nearest(1, i, pb, fd, hb);
      chk(pb != worst, "R4 worst never parent", pb, -1);
      if (is_cell) chk(fd <= CMUT, "R6 field changes", fd, CMUT);
      tally[pb]++;
      flips += hb;
    end
  endtask

  logic [CB-1:0] snap [POP*CELLS];

  task automatic take_snap();
    for (int i = 0; i < POP; i++)
      for (int c = 0; c < CELLS; c++) snap[i*CELLS+c] = ram[adr(1, i, c)];
  endtask

  function automatic int snap_diff();
    int n;
    n = 0;
    for (int i = 0; i < POP; i++)
      for (int c = 0; c < CELLS; c++) if (snap[i*CELLS+c] != ram[adr(1, i, c)]) n++;
    return n;
  endfunction

  initial begin
    int tally [4];
    int flips;
    for (int a = 0; a < 2**AW; a++) begin ram[a] = '0; wcnt[a] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy == 0 && done == 0 && mem_we == 0, "R1 reset state",
        int'({busy, done, mem_we}), 0);

    init_parents();
    load_seed(32'h1234_5678);
    // ranks: 1 (40), 2 (40, tie after 1), 0, 3 -> weights 3,2,1,0
    load_fit(10, 40, 40, 5);
    tally = '{0, 0, 0, 0};
    flips = 0;
    for (int g = 0; g < 20; g++) begin
      run_gen(1, 0, 0);
      check_gen(1, 3, 1, tally, flips);
    end
    chk(tally[3] == 0, "R4 last rank count", tally[3], 0);
    chk(tally[1] > tally[0], "R4 best above lower rank", tally[1], tally[0]);

    tally = '{0, 0, 0, 0};
    flips = 0;
    for (int g = 0; g < 20; g++) begin
      run_gen(0, 0, 0);
      check_gen(1, 3, 0, tally, flips);
    end
    // expected flips = 60 children * 24 bits * THR/65536, about 162
    chk(flips >= 100 && flips <= 230, "R5 bit-flip rate", flips,
        (60 * GBITS * THR) / 65536);

    load_fit(7, 7, 7, 7);
    run_gen(1, 0, 0);
    check_gen(0, 3, 1, tally, flips);   // R2 ties keep lower index first

    load_fit(1, 2, 3, 4);
    run_gen(0, 0, 0);
    check_gen(3, 0, 0, tally, flips);   // R2 reversed order

    load_fit(10, 40, 40, 5);
    load_seed(32'hACE1);
    run_gen(1, 0, 0);
    take_snap();
    load_seed(32'hACE1);
    run_gen(1, 0, 0);
    chk(snap_diff() == 0, "R10 same seed repeats", snap_diff(), 0);
    load_seed(32'h0);
    run_gen(0, 0, 0);
    take_snap();
    load_seed(32'h1);
    run_gen(0, 0, 0);
    chk(snap_diff() == 0, "R10 zero seed as one", snap_diff(), 0);

    run_gen(1, 0, 1);                   // R11 extra start while busy
    check_gen(1, 3, 1, tally, flips);

    run_gen(2, 1, 0);                   // random fill into bank 0
    begin
      int distinct;
      distinct = 0;
      for (int a = 1; a < POP * CELLS; a++)
        if (ram[adr(0, a / CELLS, a % CELLS)] != ram[adr(0, 0, 0)]) distinct++;
      chk(distinct > 0, "R7 random content", distinct, 1);
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule